// File: doc/BRIEF.md
# ATA device status and interrupt logic

This block sits behind the status, alternate status and command addresses of an ATA-style task file on the device side. It holds the eight status flags and presents them as one byte for host reads. It drives the active-low interrupt request line. It takes command codes from host writes and hands each accepted code to a back-end command engine through a one-cycle start pulse. The engine reports the end of the command on a done strobe, with its completion flags beside it.

A status read has side effects and an alternate status read has none. Reading the primary status address withdraws the interrupt request. The same read also applies a ready-flag change that was held back when a command finished with an error. Reading the alternate address returns the same byte but changes nothing. While a command is in progress the byte shows only the busy flag, so the host never sees flags that are out of date.

Top module: `ata_status_ctrl`

## Requirements
- R1: After reset, status_o is 0x50 (ready and seek complete set, all other bits 0), irq_n is 1 and cmd_start is 0.
- R2: status_o bit positions are: 7 busy, 6 ready, 5 write fault, 4 seek complete, 3 data request, 2 corrected data, 1 index, 0 error; the index bit always reads 0.
- R3: While busy is 1, status_o is exactly 0x80, whatever the other flags hold.
- R4: A cmd_wr taken while busy is 0, ready is 1 and seek complete is 1 is accepted. On the next clock busy is 1, cmd_start is 1 for exactly one cycle with cmd_op equal to the written code, and error, write fault and corrected data are cleared.
- R5: A cmd_wr in any other state is ignored: no cmd_start, and the status is left unchanged.
- R6: eng_done while busy clears busy on the next clock. In the same clock, error takes eng_err, write fault takes eng_fault and seek complete takes eng_seek, and irq_n goes to 0. eng_done while not busy has no effect.
- R7: On a completion with eng_err = 0, ready takes eng_ready in the same clock.
- R8: On a completion with eng_err = 1, ready keeps its old value. The new value eng_ready takes effect in the clock after the next primary status read (rd_stat). A new accepted command discards a change that is still pending.
- R9: rd_stat sets irq_n to 1 on the next clock. A completion in the same cycle takes priority and drives irq_n to 0.
- R10: rd_alt returns the same status_o and has no effect on irq_n or on a pending ready change.
- R11: drq_set sets the data request flag and drq_clr clears it, with drq_clr winning when both are high. corr_set sets the corrected data flag, but an accept in the same cycle clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stat | input | 1 | Host read of the primary status address (has side effects) |
| rd_alt | input | 1 | Host read of the alternate status address (no side effects) |
| cmd_wr | input | 1 | Host write strobe to the command address |
| cmd_code | input | 8 | Command code written by the host |
| status_o | output | 8 | Status byte returned for both read addresses |
| irq_n | output | 1 | Interrupt request, active low |
| cmd_start | output | 1 | One-cycle start pulse to the command engine |
| cmd_op | output | 8 | Accepted command code, valid with cmd_start |
| eng_done | input | 1 | Command engine completion strobe |
| eng_err | input | 1 | Completion ended in error |
| eng_fault | input | 1 | Completion reports a write fault |
| eng_seek | input | 1 | Seek-complete value reported at completion |
| eng_ready | input | 1 | Ready value reported at completion |
| drq_set | input | 1 | Data path requests a transfer |
| drq_clr | input | 1 | Data path ends the transfer request |
| corr_set | input | 1 | A correctable data error was corrected |

## Verification
The hardest case to reach is the deferred ready change. It needs an error completion that reports a ready value different from the current one. An alternate read then has to leave the value alone, and a primary read has to release it. A further command write has to be refused because ready went low. The directed part walks through this order exactly. The random part weights eng_err and eng_ready so that errored completions with ready dropping and rising happen often, and mixes both kinds of read among them. A bench model follows every flag, the pending value and the interrupt on every cycle.

// File: rtl/ata_stat_pkg.sv
package ata_stat_pkg;
  localparam int STAT_W  = 8;
  localparam int B_BSY   = 7;
  localparam int B_DRDY  = 6;
  localparam int B_DWF   = 5;
  localparam int B_DSC   = 4;
  localparam int B_DRQ   = 3;
  localparam int B_CORR  = 2;
  localparam int B_IDX   = 1;
  localparam int B_ERR   = 0;

  typedef struct packed {
    logic bsy;
    logic drdy;
    logic dwf;
    logic dsc;
    logic drq;
    logic corr;
    logic err;
  } flags_t;

  function automatic logic [STAT_W-1:0] pack_status(input flags_t f);
    logic [STAT_W-1:0] s;
    s = '0;
    if (f.bsy) begin
      s[B_BSY] = 1'b1;
    end else begin
      s[B_DRDY] = f.drdy;
      s[B_DWF]  = f.dwf;
      s[B_DSC]  = f.dsc;
      s[B_DRQ]  = f.drq;
      s[B_CORR] = f.corr;
      s[B_IDX]  = 1'b0;
      s[B_ERR]  = f.err;
    end
    return s;
  endfunction
endpackage

// File: rtl/ata_cmd_gate.sv
module ata_cmd_gate #(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             bsy,
  input  logic             drdy,
  input  logic             dsc,
  output logic             accept,
  output logic             cmd_start,
  output logic [CMD_W-1:0] cmd_op
);
  logic             start_d;
  logic [CMD_W-1:0] op_d;
  logic             op_en;

  always_comb begin
    accept  = cmd_wr && !bsy && drdy && dsc;
    start_d = accept;
    op_en   = accept;
    op_d    = cmd_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_start <= 1'b0;
      cmd_op    <= '0;
    end else begin
      cmd_start <= start_d;
      if (op_en) cmd_op <= op_d;
    end
  end

  // R5
  busy_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bsy) |=> !cmd_start);
  // R4
  start_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start);
endmodule

// File: rtl/ata_flag_regs.sv
module ata_flag_regs
  import ata_stat_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   accept,
  input  logic   done_evt,
  input  logic   eng_err,
  input  logic   eng_fault,
  input  logic   eng_seek,
  input  logic   eng_ready,
  input  logic   rd_stat,
  input  logic   drq_set,
  input  logic   drq_clr,
  input  logic   corr_set,
  output flags_t flags
);
  flags_t f_d;
  logic   pend_q, pend_d;
  logic   pval_q, pval_d;

  always_comb begin
    f_d    = flags;
    pend_d = pend_q;
    pval_d = pval_q;
    if (rd_stat && pend_q && !done_evt) begin
      f_d.drdy = pval_q;
      pend_d   = 1'b0;
    end
    if (corr_set) f_d.corr = 1'b1;
    if (accept) begin
      f_d.bsy  = 1'b1;
      f_d.err  = 1'b0;
      f_d.dwf  = 1'b0;
      f_d.corr = 1'b0;
      pend_d   = 1'b0;
    end
    if (done_evt) begin
      f_d.bsy = 1'b0;
      f_d.err = eng_err;
      f_d.dwf = eng_fault;
      f_d.dsc = eng_seek;
      if (eng_err) begin
        pend_d = 1'b1;
        pval_d = eng_ready;
      end else begin
        f_d.drdy = eng_ready;
        pend_d   = 1'b0;
      end
    end
    if (drq_clr)      f_d.drq = 1'b0;
    else if (drq_set) f_d.drq = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags  <= '{bsy: 1'b0, drdy: 1'b1, dwf: 1'b0, dsc: 1'b1,
                  drq: 1'b0, corr: 1'b0, err: 1'b0};
      pend_q <= 1'b0;
      pval_q <= 1'b0;
    end else begin
      flags  <= f_d;
      pend_q <= pend_d;
      pval_q <= pval_d;
    end
  end

  // R8
  err_ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && eng_err) |=> (flags.drdy == $past(flags.drdy)));
  // R4
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (flags.bsy && !flags.err && !flags.dwf));
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !flags.bsy);
endmodule

// File: rtl/ata_irq_ctl.sv
module ata_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic done_evt,
  input  logic rd_stat,
  input  logic rd_alt,
  output logic irq_n
);
  logic req_q, req_d;

  always_comb begin
    req_d = req_q;
    if (done_evt)     req_d = 1'b1;
    else if (rd_stat) req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign irq_n = !req_q;

  // R6
  done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !irq_n);
  // R9
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !done_evt) |=> irq_n);
  // R10
  alt_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_alt && !rd_stat && !done_evt) |=> $stable(irq_n));
endmodule

// File: rtl/ata_status_ctrl.sv
module ata_status_ctrl
  import ata_stat_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stat,
  input  logic              rd_alt,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_code,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_n,
  output logic              cmd_start,
  output logic [CMD_W-1:0]  cmd_op,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic              eng_fault,
  input  logic              eng_seek,
  input  logic              eng_ready,
  input  logic              drq_set,
  input  logic              drq_clr,
  input  logic              corr_set
);
  flags_t flags;
  logic   accept;
  logic   done_evt;

  assign done_evt = eng_done && flags.bsy;
  assign status_o = pack_status(flags);

  ata_cmd_gate #(.CMD_W(CMD_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .bsy(flags.bsy), .drdy(flags.drdy), .dsc(flags.dsc),
    .accept(accept), .cmd_start(cmd_start), .cmd_op(cmd_op)
  );

  ata_flag_regs u_flags (
    .clk(clk), .rst_n(rst_n), .accept(accept), .done_evt(done_evt),
    .eng_err(eng_err), .eng_fault(eng_fault), .eng_seek(eng_seek),
    .eng_ready(eng_ready), .rd_stat(rd_stat), .drq_set(drq_set),
    .drq_clr(drq_clr), .corr_set(corr_set), .flags(flags)
  );

  ata_irq_ctl u_irq (
    .clk(clk), .rst_n(rst_n), .done_evt(done_evt), .rd_stat(rd_stat),
    .rd_alt(rd_alt), .irq_n(irq_n)
  );

  // R3
  busy_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start) |-> (status_o == 8'h80));
endmodule

// File: tb/sim_ata_status_ctrl.sv
module sim_ata_status_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SEED = 32'h5A17;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_stat = 0, rd_alt = 0, cmd_wr = 0;
  logic [7:0] cmd_code = 0;
  logic [7:0] status_o;
  logic       irq_n, cmd_start;
  logic [7:0] cmd_op;
  logic       eng_done = 0, eng_err = 0, eng_fault = 0, eng_seek = 0, eng_ready = 0;
  logic       drq_set = 0, drq_clr = 0, corr_set = 0;

  int n_chk = 0, n_fail = 0;

  // bench model state
  logic m_bsy, m_drdy, m_dwf, m_dsc, m_drq, m_corr, m_err, m_pend, m_pval, m_irq;
  logic m_start;
  logic [7:0] m_op;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_status_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .rd_stat(rd_stat), .rd_alt(rd_alt),
    .cmd_wr(cmd_wr), .cmd_code(cmd_code), .status_o(status_o), .irq_n(irq_n),
    .cmd_start(cmd_start), .cmd_op(cmd_op), .eng_done(eng_done),
    .eng_err(eng_err), .eng_fault(eng_fault), .eng_seek(eng_seek),
    .eng_ready(eng_ready), .drq_set(drq_set), .drq_clr(drq_clr),
    .corr_set(corr_set)
  );

  function automatic logic [7:0] exp_status();
    if (m_bsy) return 8'h80;
    return {1'b0, m_drdy, m_dwf, m_dsc, m_drq, m_corr, 1'b0, m_err};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_bsy = 0; m_drdy = 1; m_dwf = 0; m_dsc = 1; m_drq = 0; m_corr = 0;
    m_err = 0; m_pend = 0; m_pval = 0; m_irq = 0; m_start = 0; m_op = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    {rd_stat, rd_alt, cmd_wr, eng_done, drq_set, drq_clr, corr_set} = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_reset();
    @(negedge clk);
  endtask

  task automatic step(input logic wr, input logic [7:0] code, input logic rd,
                      input logic alt, input logic dn, input logic e,
                      input logic flt, input logic sk, input logic rdy,
                      input logic ds, input logic dc, input logic cs,
                      input string tag);
    logic acc, de;
    cmd_wr = wr; cmd_code = code; rd_stat = rd; rd_alt = alt;
    eng_done = dn; eng_err = e; eng_fault = flt; eng_seek = sk; eng_ready = rdy;
    drq_set = ds; drq_clr = dc; corr_set = cs;
    acc = wr && !m_bsy && m_drdy && m_dsc;
    de  = dn && m_bsy;
    if (rd && m_pend && !de) begin m_drdy = m_pval; m_pend = 0; end
    if (cs) m_corr = 1;
    if (acc) begin
      m_bsy = 1; m_err = 0; m_dwf = 0; m_corr = 0; m_pend = 0; m_op = code;
    end
    m_start = acc;
    if (de) begin
      m_bsy = 0; m_err = e; m_dwf = flt; m_dsc = sk;
      if (e) begin m_pend = 1; m_pval = rdy; end
      else begin m_drdy = rdy; m_pend = 0; end
    end
    if (dc) m_drq = 0; else if (ds) m_drq = 1;
    if (de) m_irq = 1; else if (rd) m_irq = 0;
    @(posedge clk);
    #1;
    {cmd_wr, rd_stat, rd_alt, eng_done, drq_set, drq_clr, corr_set} = '0;
    chk({tag, " status"}, status_o, exp_status());
    chk({tag, " irq_n"}, {7'd0, irq_n}, {7'd0, !m_irq});
    chk({tag, " start"}, {7'd0, cmd_start}, {7'd0, m_start});
    if (m_start) chk({tag, " op"}, cmd_op, m_op);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int r;
    r = $urandom(SEED);
    do_reset();
    // R1 reset state
    chk("R1 status", status_o, 8'h50);
    chk("R1 irq_n", {7'd0, irq_n}, 8'd1);
    chk("R1 start", {7'd0, cmd_start}, 8'd0);

    // R4 accept
    step(1, 8'h20, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 accept");
    chk("R4 op", cmd_op, 8'h20);
    idle("R4 pulse end");
    // R5 write while busy
    step(1, 8'h30, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5 busy write");
    // R3 flags hidden while busy
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1, "R3 masked");
    chk("R3 mask", status_o, 8'h80);
    // R6 R7 clean completion
    step(0, 0, 0, 0, 1, 0, 0, 1, 1, 0, 0, 0, "R6 R7 done");
    chk("R2 bits", status_o, 8'h5C);
    // R10 alt read keeps irq
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R10 alt");
    chk("R10 irq kept", {7'd0, irq_n}, 8'd0);
    // R9 primary read clears irq
    step(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0, "R9 read");
    chk("R9 irq cleared", {7'd0, irq_n}, 8'd1);
    // R8 error completion with ready falling
    step(1, 8'hCA, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 accept2");
    step(0, 0, 0, 0, 1, 1, 1, 1, 0, 0, 0, 0, "R8 err done");
    chk("R8 ready held", status_o, 8'h71);
    step(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R10 alt pend");
    chk("R10 pend kept", status_o, 8'h71);
    step(0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8 release");
    chk("R8 ready applied", status_o, 8'h31);
    // R5 not ready
    step(1, 8'h40, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R5 not ready");
    chk("R5 unchanged", status_o, 8'h31);
    // R11 drq and corr
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, "R11 drq set");
    chk("R11 drq", status_o, 8'h39);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, "R11 clr wins");
    chk("R11 clr corr", status_o, 8'h35);

    // R6 done while idle ignored, R9 same-cycle priority
    do_reset();
    step(0, 0, 0, 0, 1, 1, 1, 0, 0, 0, 0, 0, "R6 idle done");
    chk("R6 ignored", status_o, 8'h50);
    step(1, 8'h11, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R4 accept3");
    step(0, 0, 1, 0, 1, 0, 0, 1, 1, 0, 0, 0, "R9 done wins");
    chk("R9 irq set", {7'd0, irq_n}, 8'd0);

    // random mix against model (R2..R11)
    for (int i = 0; i < 3000; i++) begin
      logic wr, rd, alt, dn, e, ds, dc, cs;
      wr  = ($urandom % 4) == 0;
      rd  = ($urandom % 4) == 0;
      alt = ($urandom % 4) == 0;
      dn  = m_bsy ? (($urandom % 3) == 0) : (($urandom % 8) == 0);
      e   = ($urandom % 2) == 0;
      ds  = ($urandom % 6) == 0;
      dc  = ($urandom % 6) == 0;
      cs  = ($urandom % 8) == 0;
      step(wr, 8'($urandom), rd, alt, dn, e, 1'($urandom),
           ($urandom % 5) != 0, 1'($urandom), ds, dc, cs, "RND R8 R11");
      if (!m_drdy && ($urandom % 16) == 0) do_reset();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule